// File: doc/BRIEF.md
# SD Host Data Phase Engine

This block runs the data phase of an SD host controller. Software, or a register front end, loads a total byte length, a timeout count and a control word. Once the control word starts a transfer, the engine moves 32-bit words between a host-side data window and an internal word FIFO. On the other side it trades single bytes with a card-side valid/ready stream. The blocks that serialise the bus, check the CRC and handle commands sit on that stream and are not part of this block.

Progress toward the host is shown in one of two ways. In programmed I/O mode, two level flags report that there is room for a batch of words (write to card) or that a batch of words is waiting (read from card). In DMA mode, one request line replaces both flags. The transfer ends with a sticky data-end flag once every byte has crossed both sides. A transfer that stalls ends with a sticky timeout flag when the cycle budget runs out. The engine also marks the last byte of every block on the card side, so the serialiser knows where to close a CRC frame.

Top module: `sdd_data_engine`

## Requirements
- R1: After reset, every flag, request and stream-valid/ready output is low, and `fifo_depth` reports the FIFO depth in 32-bit words (default 8).
- R2: The control word, applied by `ctl_we`, uses these bits: bit 8 flush, bit 7 half threshold, bit 6 enable, bit 5 DMA mode, bit 4 direction (1 = toward the card), bits 3:0 log2 of the block size in bytes. A write with bit 6 set starts a transfer of the last written length. A write with bit 6 clear stops any transfer. Every control write clears data-end and timeout.
- R3: Toward the card, each accepted window word leaves on the card stream as four bytes, least significant byte first.
- R4: From the card, every four stream bytes are packed least significant byte first into one word, and that word is presented on `win_rdata`.
- R5: The engine ignores a window write or read when no transfer is active, when the direction is wrong, when the FIFO is full (write) or empty (read), or when the host side has already moved the whole length. Bits 1:0 of the length are ignored. Each accepted window word counts as 4 bytes.
- R6: In programmed I/O mode the room flag is high when the free words reach the threshold. The data flag is high when the stored words reach the threshold, or when the FIFO is non-empty and holds every byte the host still has to read. The threshold is the full depth, or half of it when bit 7 is set.
- R7: In DMA mode both flags stay low. `dma_req` is high while host bytes remain and the FIFO is not full (toward the card) or not empty (from the card).
- R8: `data_end` rises one cycle after both the host-side and the card-side remaining counts reach zero, and the transfer stops. A zero length ends the transfer one cycle after the start.
- R9: The timer counts down once per active cycle. If it is zero while the transfer is unfinished, `data_timeout` is set and the transfer stops.
- R10: A control write with bit 8 set empties the FIFO and stops any transfer. It starts nothing, even when bit 6 is also set.
- R11: `crd_blk_last` is high while the card-side byte being offered is the last byte of a block, that is, when the byte index within the transfer modulo the block size equals the block size minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_word | input | 9 | Control word |
| len_we | input | 1 | Length write strobe |
| len_value | input | 24 | Total byte length |
| tmr_we | input | 1 | Timer load strobe |
| tmr_value | input | 32 | Timeout budget in cycles |
| win_wr | input | 1 | Window word write |
| win_wdata | input | 32 | Window write data |
| win_rd | input | 1 | Window word read (pops the FIFO) |
| win_rdata | output | 32 | Word at the FIFO head |
| fifo_depth | output | 8 | FIFO depth in words |
| room_flag | output | 1 | PIO: room for a batch toward the card |
| data_flag | output | 1 | PIO: batch ready from the card |
| dma_req | output | 1 | DMA service request |
| data_end | output | 1 | Sticky transfer complete |
| data_timeout | output | 1 | Sticky transfer timeout |
| crd_tx_valid | output | 1 | Byte toward the card valid |
| crd_tx_data | output | 8 | Byte toward the card |
| crd_tx_ready | input | 1 | Card side accepts the byte |
| crd_rx_valid | input | 1 | Byte from the card valid |
| crd_rx_data | input | 8 | Byte from the card |
| crd_rx_ready | output | 1 | Engine accepts the byte |
| crd_blk_last | output | 1 | Current card byte closes a block |

## Verification
Some properties are checked every cycle. The FIFO is never pushed while full or popped while empty. The byte-lane index holds when no byte moves. The block offset stays inside the block. Data-end rises only out of an active transfer. A timeout rises only after the timer reached zero. A DMA request toward the card never meets a full FIFO. Other behaviour only the bench scenarios can show: byte order and data integrity in both directions, batch sizing at both thresholds, the partial-batch read flag, block-boundary marking for several block sizes, flush and abort, length rounding, and the end-versus-timeout outcome under stalled or silent card streams.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

    localparam int CTL_W    = 9;
    localparam int BLK_W    = 4;
    localparam int OFF_W    = 15;

    typedef struct packed {
        logic             flush;
        logic             half_thr;
        logic             enable;
        logic             dma;
        logic             to_card;
        logic [BLK_W-1:0] blk_log2;
    } sdd_ctl_t;

    function automatic sdd_ctl_t sdd_decode(input logic [CTL_W-1:0] w);
        sdd_ctl_t c;
        c.flush    = w[8];
        c.half_thr = w[7];
        c.enable   = w[6];
        c.dma      = w[5];
        c.to_card  = w[4];
        c.blk_log2 = w[3:0];
        return c;
    endfunction

endpackage

// File: rtl/sdd_word_fifo.sv
module sdd_word_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t q, d;

    always_comb begin
        d = q;
        if (flush) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (push) begin
                d.mem[q.wp] = wdata;
                d.wp        = q.wp + AW'(1);
            end
            if (pop) begin
                d.rp = q.rp + AW'(1);
            end
            d.cnt = q.cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign count = q.cnt;

    // R5
    push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (q.cnt < CNT_W'(DEPTH)));
    // R5
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !flush) |-> (q.cnt != '0));

endmodule

// File: rtl/sdd_card_lane.sv
module sdd_card_lane (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        tx_go,
    input  logic        rx_go,
    input  logic [31:0] head,
    input  logic        fifo_empty,
    input  logic        fifo_full,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        lane_pop,
    output logic        lane_push,
    output logic [31:0] pack_word,
    output logic        step
);

    typedef struct packed {
        logic [1:0]  idx;
        logic [23:0] pack;
    } lane_t;

    lane_t q, d;
    logic  tx_fire, rx_fire;

    assign tx_valid  = tx_go && !fifo_empty;
    assign tx_data   = head[{q.idx, 3'b000} +: 8];
    assign rx_ready  = rx_go && ((q.idx != 2'd3) || !fifo_full);
    assign tx_fire   = tx_valid && tx_ready;
    assign rx_fire   = rx_valid && rx_ready;
    assign step      = tx_fire || rx_fire;
    assign lane_pop  = tx_fire && (q.idx == 2'd3);
    assign lane_push = rx_fire && (q.idx == 2'd3);
    assign pack_word = {rx_data, q.pack};

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (step) begin
            d.idx = q.idx + 2'd1;
            if (rx_fire && (q.idx != 2'd3)) begin
                d.pack[{q.idx, 3'b000} +: 8] = rx_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !tx_fire && !rx_fire) |=> $stable(q.idx));

endmodule

// File: rtl/sdd_xfer_ctrl.sv
module sdd_xfer_ctrl
    import sdd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 24,
    parameter int TMR_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_word,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_value,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_value,
    input  logic             win_wr,
    input  logic             win_rd,
    input  logic             card_step,
    input  logic [CNT_W-1:0] fifo_count,
    output logic             active,
    output logic             to_card,
    output logic             card_left,
    output logic             flush,
    output logic             host_push,
    output logic             host_pop,
    output logic             room_flag,
    output logic             data_flag,
    output logic             dma_req,
    output logic             data_end,
    output logic             data_timeout,
    output logic             blk_last
);

    typedef struct packed {
        logic               active;
        logic               to_card;
        logic               dma;
        logic               half_thr;
        logic [BLK_W-1:0]   blk;
        logic [LEN_W-3:0]   len_words;
        logic [LEN_W-1:0]   host_rem;
        logic [LEN_W-1:0]   card_rem;
        logic [TMR_W-1:0]   tmr;
        logic [OFF_W-1:0]   blk_off;
        logic               done;
        logic               tmo;
    } ctrl_t;

    ctrl_t            q, d;
    sdd_ctl_t         ctl;
    logic             len_lsb_unused;
    logic             fifo_full, fifo_empty, host_left, pio;
    logic [CNT_W-1:0] free_words, thr_words;
    logic [LEN_W-1:0] held_bytes;
    logic [OFF_W-1:0] blk_mask;

    assign ctl            = sdd_decode(ctl_word);
    assign len_lsb_unused = ^len_value[1:0];

    assign fifo_full  = (fifo_count == CNT_W'(DEPTH));
    assign fifo_empty = (fifo_count == '0);
    assign host_left  = (q.host_rem != '0);
    assign card_left  = (q.card_rem != '0);
    assign free_words = CNT_W'(DEPTH) - fifo_count;
    assign thr_words  = q.half_thr ? CNT_W'(DEPTH / 2) : CNT_W'(DEPTH);
    assign held_bytes = LEN_W'(fifo_count) << 2;
    assign blk_mask   = OFF_W'((32'd1 << q.blk) - 32'd1);

    assign host_push  = win_wr && q.active && q.to_card && host_left && !fifo_full;
    assign host_pop   = win_rd && q.active && !q.to_card && host_left && !fifo_empty;

    assign pio        = q.active && !q.dma && host_left;
    assign room_flag  = pio && q.to_card && (free_words >= thr_words);
    assign data_flag  = pio && !q.to_card &&
                        ((fifo_count >= thr_words) ||
                         (!fifo_empty && (held_bytes >= q.host_rem)));
    assign dma_req    = q.active && q.dma && host_left &&
                        (q.to_card ? !fifo_full : !fifo_empty);

    assign active       = q.active;
    assign to_card      = q.to_card;
    assign flush        = ctl_we && ctl.flush;
    assign data_end     = q.done;
    assign data_timeout = q.tmo;
    assign blk_last     = q.active && (q.blk_off == blk_mask);

    always_comb begin
        d = q;
        if (ctl_we) begin
            d.done     = 1'b0;
            d.tmo      = 1'b0;
            d.active   = ctl.enable && !ctl.flush;
            d.to_card  = ctl.to_card;
            d.dma      = ctl.dma;
            d.half_thr = ctl.half_thr;
            d.blk      = ctl.blk_log2;
            d.blk_off  = '0;
            d.host_rem = {q.len_words, 2'b00};
            d.card_rem = {q.len_words, 2'b00};
        end else if (q.active) begin
            if (host_push || host_pop) begin
                d.host_rem = q.host_rem - LEN_W'(4);
            end
            if (card_step) begin
                d.card_rem = q.card_rem - LEN_W'(1);
                d.blk_off  = (q.blk_off == blk_mask) ? '0 : q.blk_off + OFF_W'(1);
            end
            if (!host_left && !card_left) begin
                d.done   = 1'b1;
                d.active = 1'b0;
            end else if (q.tmr == '0) begin
                d.tmo    = 1'b1;
                d.active = 1'b0;
            end else begin
                d.tmr = q.tmr - TMR_W'(1);
            end
        end
        if (len_we) d.len_words = len_value[LEN_W-1:2];
        if (tmr_we) d.tmr       = tmr_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    dma_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && q.to_card) |-> (fifo_count < CNT_W'(DEPTH)));
    // R8
    end_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> $past(q.active));
    // R9
    tmo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.tmo) |-> ($past(q.tmr) == '0));
    // R11
    blk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.blk_off <= blk_mask);

endmodule

// File: rtl/sdd_data_engine.sv
module sdd_data_engine
    import sdd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 24,
    parameter int TMR_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_word,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_value,
    input  logic             tmr_we,
    input  logic [TMR_W-1:0] tmr_value,
    input  logic             win_wr,
    input  logic [31:0]      win_wdata,
    input  logic             win_rd,
    output logic [31:0]      win_rdata,
    output logic [7:0]       fifo_depth,
    output logic             room_flag,
    output logic             data_flag,
    output logic             dma_req,
    output logic             data_end,
    output logic             data_timeout,
    output logic             crd_tx_valid,
    output logic [7:0]       crd_tx_data,
    input  logic             crd_tx_ready,
    input  logic             crd_rx_valid,
    input  logic [7:0]       crd_rx_data,
    output logic             crd_rx_ready,
    output logic             crd_blk_last
);

    logic             active, to_card, card_left, flush;
    logic             host_push, host_pop, lane_push, lane_pop, step;
    logic [CNT_W-1:0] count;
    logic [31:0]      head, pack_word;

    sdd_xfer_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .TMR_W(TMR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_we       (ctl_we),
        .ctl_word     (ctl_word),
        .len_we       (len_we),
        .len_value    (len_value),
        .tmr_we       (tmr_we),
        .tmr_value    (tmr_value),
        .win_wr       (win_wr),
        .win_rd       (win_rd),
        .card_step    (step),
        .fifo_count   (count),
        .active       (active),
        .to_card      (to_card),
        .card_left    (card_left),
        .flush        (flush),
        .host_push    (host_push),
        .host_pop     (host_pop),
        .room_flag    (room_flag),
        .data_flag    (data_flag),
        .dma_req      (dma_req),
        .data_end     (data_end),
        .data_timeout (data_timeout),
        .blk_last     (crd_blk_last)
    );

    sdd_word_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (host_push || lane_push),
        .wdata (to_card ? win_wdata : pack_word),
        .pop   (host_pop || lane_pop),
        .head  (head),
        .count (count)
    );

    sdd_card_lane u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (ctl_we),
        .tx_go      (active && to_card && card_left),
        .rx_go      (active && !to_card && card_left),
        .head       (head),
        .fifo_empty (count == '0),
        .fifo_full  (count == CNT_W'(DEPTH)),
        .tx_valid   (crd_tx_valid),
        .tx_data    (crd_tx_data),
        .tx_ready   (crd_tx_ready),
        .rx_valid   (crd_rx_valid),
        .rx_data    (crd_rx_data),
        .rx_ready   (crd_rx_ready),
        .lane_pop   (lane_pop),
        .lane_push  (lane_push),
        .pack_word  (pack_word),
        .step       (step)
    );

    assign win_rdata  = head;
    assign fifo_depth = 8'(DEPTH);

endmodule

// File: tb/sdd_data_engine_tb.sv
module sdd_data_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    typedef struct packed {
        logic        to_card;
        logic        dma;
        logic        half;
        logic        stall;
        logic        dead;
        logic [3:0]  blk;
        logic [23:0] len;
        logic [15:0] tmr;
        logic        exp_end;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 24'd64,  16'd3000, 1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 24'd100, 16'd3000, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4, 24'd36,  16'd3000, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 24'd40,  16'd3000, 1'b1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5, 24'd68,  16'd3000, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3, 24'd128, 16'd3000, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 24'd32,  16'd20,   1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 24'd64,  16'd30,   1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 24'd6,   16'd3000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [8:0]  ctl_word = '0;
    logic        len_we = 1'b0;
    logic [23:0] len_value = '0;
    logic        tmr_we = 1'b0;
    logic [31:0] tmr_value = '0;
    logic        win_wr = 1'b0;
    logic [31:0] win_wdata = '0;
    logic        win_rd = 1'b0;
    logic [31:0] win_rdata;
    logic [7:0]  fifo_depth;
    logic        room_flag, data_flag, dma_req, data_end, data_timeout;
    logic        crd_tx_valid;
    logic [7:0]  crd_tx_data;
    logic        crd_tx_ready = 1'b0;
    logic        crd_rx_valid = 1'b0;
    logic [7:0]  crd_rx_data = '0;
    logic        crd_rx_ready, crd_blk_last;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdd_data_engine #(.DEPTH(DEPTH)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .ctl_we (ctl_we), .ctl_word (ctl_word),
        .len_we (len_we), .len_value (len_value),
        .tmr_we (tmr_we), .tmr_value (tmr_value),
        .win_wr (win_wr), .win_wdata (win_wdata),
        .win_rd (win_rd), .win_rdata (win_rdata),
        .fifo_depth (fifo_depth),
        .room_flag (room_flag), .data_flag (data_flag), .dma_req (dma_req),
        .data_end (data_end), .data_timeout (data_timeout),
        .crd_tx_valid (crd_tx_valid), .crd_tx_data (crd_tx_data),
        .crd_tx_ready (crd_tx_ready),
        .crd_rx_valid (crd_rx_valid), .crd_rx_data (crd_rx_data),
        .crd_rx_ready (crd_rx_ready), .crd_blk_last (crd_blk_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int v, input int k);
        return 8'(k * 13 + v * 29 + 5);
    endfunction

    function automatic logic [31:0] word_of(input int v, input int w);
        return {pat(v, 4*w+3), pat(v, 4*w+2), pat(v, 4*w+1), pat(v, 4*w)};
    endfunction

    // called at a negedge, returns at the next negedge with the write applied
    task automatic put_ctl(input logic [8:0] w);
        ctl_word = w;
        ctl_we   = 1'b1;
        @(negedge clk);
        ctl_we   = 1'b0;
    endtask

    task automatic load(input logic [23:0] len, input logic [31:0] tmr);
        len_value = len;
        tmr_value = tmr;
        len_we    = 1'b1;
        tmr_we    = 1'b1;
        @(negedge clk);
        len_we    = 1'b0;
        tmr_we    = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] w);
        win_wdata = w;
        win_wr    = 1'b1;
        @(negedge clk);
        win_wr    = 1'b0;
    endtask

    task automatic run_vec(input int v);
        vec_t t;
        int nbytes, nwords, thr_w, bs, k, hw, hr, batch, cyc;
        bit fin, ok;
        t      = VEC[v];
        nbytes = int'(t.len) & ~32'd3;
        nwords = nbytes / 4;
        thr_w  = t.half ? DEPTH / 2 : DEPTH;
        bs     = 1 << t.blk;
        k = 0; hw = 0; hr = 0; batch = 0; cyc = 0; fin = 1'b0;
        put_ctl(9'h100);
        load(t.len, 32'(t.tmr));
        put_ctl({1'b0, t.half, 1'b1, t.dma, t.to_card, t.blk});
        while (!fin && cyc < 5000) begin
            win_wr = 1'b0; win_rd = 1'b0; crd_tx_ready = 1'b0; crd_rx_valid = 1'b0;
            if (data_end || data_timeout) begin
                fin = 1'b1;
            end else begin
                ok = !t.dead && (!t.stall || (cyc % 3 != 0));
                if (t.to_card) begin
                    crd_tx_ready = ok;
                    if (ok && crd_tx_valid) begin
                        chk("R3 card byte", 32'(crd_tx_data), 32'(pat(v, k)));
                        chk("R11 block last", 32'(crd_blk_last), 32'((k % bs) == bs - 1));
                        k++;
                    end
                end else if (ok && k < nbytes) begin
                    crd_rx_valid = 1'b1;
                    crd_rx_data  = pat(v, k);
                    if (crd_rx_ready) begin
                        chk("R11 block last", 32'(crd_blk_last), 32'((k % bs) == bs - 1));
                        k++;
                    end
                end
                if (t.dma) begin
                    if (dma_req && t.to_card && hw < nwords) begin
                        win_wr = 1'b1; win_wdata = word_of(v, hw); hw++;
                    end else if (dma_req && !t.to_card) begin
                        win_rd = 1'b1;
                        chk("R4 window word", win_rdata, word_of(v, hr)); hr++;
                    end
                end else begin
                    if (batch == 0 && t.to_card && room_flag)
                        batch = (nwords - hw < thr_w) ? nwords - hw : thr_w;
                    if (batch == 0 && !t.to_card && data_flag)
                        batch = (nwords - hr < thr_w) ? nwords - hr : thr_w;
                    if (batch > 0) begin
                        if (t.to_card) begin
                            win_wr = 1'b1; win_wdata = word_of(v, hw); hw++;
                        end else begin
                            win_rd = 1'b1;
                            chk("R4 window word", win_rdata, word_of(v, hr)); hr++;
                        end
                        batch--;
                    end
                end
                @(negedge clk);
                cyc++;
            end
        end
        win_wr = 1'b0; win_rd = 1'b0; crd_tx_ready = 1'b0; crd_rx_valid = 1'b0;
        chk("R8 data end", 32'(data_end), 32'(t.exp_end));
        chk("R9 data timeout", 32'(data_timeout), 32'(!t.exp_end));
        if (t.exp_end) begin
            chk("R3 R4 card bytes moved", 32'(k), 32'(nbytes));
            chk("R5 host words moved", 32'(t.to_card ? hw : hr), 32'(nwords));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 room", 32'(room_flag), 0);
        chk("R1 data", 32'(data_flag), 0);
        chk("R1 dma", 32'(dma_req), 0);
        chk("R1 end", 32'(data_end), 0);
        chk("R1 timeout", 32'(data_timeout), 0);
        chk("R1 tx valid", 32'(crd_tx_valid), 0);
        chk("R1 rx ready", 32'(crd_rx_ready), 0);
        chk("R1 depth", 32'(fifo_depth), DEPTH);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R8 zero length ends one cycle after start
        put_ctl(9'h100);
        load(24'd0, 32'd5000);
        put_ctl(9'h052);
        chk("R8 zero length not yet", 32'(data_end), 0);
        @(negedge clk);
        chk("R8 zero length end", 32'(data_end), 1);
        // R2 next control write clears the sticky end
        put_ctl(9'h000);
        chk("R2 end cleared", 32'(data_end), 0);

        // R5 window writes while idle are ignored
        put_ctl(9'h100);
        for (int i = 0; i < 3; i++) push_word(32'hDEAD0000 + 32'(i));
        load(24'd64, 32'd5000);
        put_ctl(9'h052);
        chk("R5 idle writes ignored", 32'(room_flag), 1);
        chk("R5 no stale byte", 32'(crd_tx_valid), 0);
        for (int i = 0; i < 3; i++) push_word(32'h11223344);
        chk("R6 room low when partly filled", 32'(room_flag), 0);
        chk("R3 first byte low lane", 32'(crd_tx_data), 32'h44);
        // R10 flush wins over enable and starts nothing
        put_ctl(9'h152);
        chk("R10 no start valid", 32'(crd_tx_valid), 0);
        chk("R10 no start room", 32'(room_flag), 0);
        put_ctl(9'h052);
        chk("R10 fifo emptied", 32'(room_flag), 1);
        chk("R10 fifo emptied tx", 32'(crd_tx_valid), 0);

        // R6 half threshold
        put_ctl(9'h100);
        load(24'd64, 32'd5000);
        put_ctl(9'h0D2);
        for (int i = 0; i < DEPTH / 2; i++) push_word(32'(i));
        chk("R6 half room kept", 32'(room_flag), 1);
        push_word(32'h5);
        chk("R6 half room lost", 32'(room_flag), 0);
        // R2 enable clear stops the transfer
        put_ctl(9'h012);
        chk("R2 abort tx", 32'(crd_tx_valid), 0);
        chk("R2 abort room", 32'(room_flag), 0);

        // R7 DMA request replaces flags
        put_ctl(9'h100);
        load(24'd64, 32'd5000);
        put_ctl(9'h072);
        chk("R7 dma write req", 32'(dma_req), 1);
        chk("R7 dma no room flag", 32'(room_flag), 0);
        put_ctl(9'h100);
        load(24'd64, 32'd5000);
        put_ctl(9'h062);
        chk("R7 dma read idle", 32'(dma_req), 0);
        for (int i = 0; i < 4; i++) begin
            crd_rx_valid = 1'b1;
            crd_rx_data  = 8'h10 + 8'(i);
            @(negedge clk);
        end
        crd_rx_valid = 1'b0;
        chk("R7 dma read req", 32'(dma_req), 1);
        chk("R7 dma no data flag", 32'(data_flag), 0);
        chk("R4 packed word", win_rdata, 32'h13121110);
        // R5 window write in read direction ignored: still one word, req stays
        push_word(32'hFFFFFFFF);
        chk("R5 wrong direction write", win_rdata, 32'h13121110);
        put_ctl(9'h100);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule